// File: doc/BRIEF.md
# Rewindable Status-Flagged FIFO

A single-clock first-in first-out buffer for 9-bit words with a power-of-two depth (default 1024). Words leave in the order they arrived, with no address supplied by either side. Write and read strobes are active low and are sampled at each rising clock edge as per-cycle enables. Four active-low flags report occupancy: full, empty, more-than-half-full, and a combined edge flag that goes low when the buffer is nearly empty or nearly full.

A rewind input moves the read side back to the first storage location and leaves the write side alone, so a block of data written since reset can be sent again. An output-enable input blanks the data bus. The read still takes place while the bus is blanked. The bus is modelled as a registered data word plus a valid bit. While the valid bit is low, the data word is zero.

Top module: `rewind_fifo`

## Requirements
- R1: While `rstN` is low, `fullN` and `halfN` are high, and `emptyN` and `edgeN` are low. `rdValid` is 0 and `rdData` is 0.
- R2: A write strobe while `fullN` is low is ignored. The stored words and the flags are unchanged.
- R3: A read strobe while `emptyN` is low is ignored. `rdValid` stays 0 and the read position does not move, so the next word written is the next word read.
- R4: For depth N, `edgeN` is low when occupancy is below N/8 or above 7N/8. It is high from N/8 through 7N/8 inclusive.
- R5: `halfN` is low exactly when occupancy is greater than N/2.
- R6: `fullN` is low only at occupancy N, and `emptyN` is low only at occupancy 0.
- R7: After an edge where a read is accepted and `oeN` is low, `rdValid` is 1 and `rdData` holds that word, one cycle later. Otherwise `rdValid` is 0 and `rdData` is 0, including when `oeN` is low and no read is made.
- R8: A read accepted while `oeN` is high gives `rdValid` = 0, but it still consumes the word.
- R9: A simultaneous read and write on a buffer that is neither empty nor full leaves occupancy unchanged. On an empty buffer only the write happens. On a full buffer only the read happens.
- R10: A low `rewindN` returns the read position to the first location and leaves the write position unchanged. Occupancy becomes the number of words written since reset, provided that number is at most N. Read and write strobes in a rewind cycle are ignored.
- R11: Read and write strobes present while `rstN` is low are ignored.
- R12: Words are read out in the order they were written.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rstN | input | 1 | Asynchronous reset, active low |
| wrN | input | 1 | Write strobe, active low |
| rdN | input | 1 | Read strobe, active low |
| rewindN | input | 1 | Rewind read position to first location, active low |
| oeN | input | 1 | Output enable, active low |
| wrData | input | DATA_W | Word to store |
| rdData | output | DATA_W | Word read out, zero when not valid |
| rdValid | output | 1 | Data bus driven (read with output enabled) |
| fullN | output | 1 | Low when occupancy is N |
| emptyN | output | 1 | Low when occupancy is 0 |
| halfN | output | 1 | Low when occupancy exceeds N/2 |
| edgeN | output | 1 | Low in the bottom or top eighth of occupancy |

## Verification
The hardest case to reach is a rewind after partial reads, with both strobes asserted in the same cycle. The buffer must hold data written since reset, part of it already consumed, and the rewind must still restore the full count and the original order. The bench uses a depth of 16 so every occupancy from empty to full can be swept with the flags compared each step. It then resets, writes ten words, reads six, and applies rewind with both strobes held low. Finally it drains the buffer and checks all ten words in order.

// File: rtl/rewind_fifo_pkg.sv
package rewind_fifo_pkg;
  typedef struct packed {
    logic wrEn;
    logic rdEn;
    logic showEn;
  } fifoStb_t;
endpackage

// File: rtl/rewind_fifo_ctl.sv
module rewind_fifo_ctl
  import rewind_fifo_pkg::*;
#(
  parameter int DEPTH = 1024,
  localparam int AW = $clog2(DEPTH)
) (
  input  logic          clk,
  input  logic          rstN,
  input  logic          wrN,
  input  logic          rdN,
  input  logic          rewindN,
  input  logic          oeN,
  output fifoStb_t      stb,
  output logic [AW-1:0] wrAddr,
  output logic [AW-1:0] rdAddr,
  output logic          fullN,
  output logic          emptyN,
  output logic          halfN,
  output logic          edgeN
);
  localparam logic [AW:0] FULL_CNT = (AW+1)'(DEPTH);
  localparam logic [AW:0] LOW_CNT  = (AW+1)'(DEPTH / 8);
  localparam logic [AW:0] HIGH_CNT = (AW+1)'(DEPTH - DEPTH / 8);
  localparam logic [AW:0] HALF_CNT = (AW+1)'(DEPTH / 2);

  logic [AW:0] wrPtr, rdPtr, occ;
  logic        isFull, isEmpty;

  assign occ     = wrPtr - rdPtr;
  assign isFull  = (occ == FULL_CNT);
  assign isEmpty = (occ == '0);

  always_comb begin
    stb.wrEn   = rewindN && !wrN && !isFull;
    stb.rdEn   = rewindN && !rdN && !isEmpty;
    stb.showEn = !oeN;
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      wrPtr <= '0;
      rdPtr <= '0;
    end else if (!rewindN) begin
      rdPtr <= '0;
    end else begin
      if (stb.wrEn) wrPtr <= wrPtr + 1'b1;
      if (stb.rdEn) rdPtr <= rdPtr + 1'b1;
    end
  end

  assign wrAddr = wrPtr[AW-1:0];
  assign rdAddr = rdPtr[AW-1:0];
  assign fullN  = !isFull;
  assign emptyN = !isEmpty;
  assign halfN  = !(occ > HALF_CNT);
  assign edgeN  = !((occ < LOW_CNT) || (occ > HIGH_CNT));
endmodule

// File: rtl/rewind_fifo_dp.sv
module rewind_fifo_dp
  import rewind_fifo_pkg::*;
#(
  parameter int DEPTH  = 1024,
  parameter int DATA_W = 9,
  localparam int AW = $clog2(DEPTH)
) (
  input  logic              clk,
  input  logic              rstN,
  input  fifoStb_t          stb,
  input  logic [AW-1:0]     wrAddr,
  input  logic [AW-1:0]     rdAddr,
  input  logic [DATA_W-1:0] wrData,
  output logic [DATA_W-1:0] rdData,
  output logic              rdValid
);
  logic [DATA_W-1:0] store [DEPTH];

  always_ff @(posedge clk) begin
    if (stb.wrEn) store[wrAddr] <= wrData;
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      rdValid <= 1'b0;
      rdData  <= '0;
    end else begin
      rdValid <= stb.rdEn && stb.showEn;
      rdData  <= (stb.rdEn && stb.showEn) ? store[rdAddr] : '0;
    end
  end
endmodule

// File: rtl/rewind_fifo.sv
module rewind_fifo
  import rewind_fifo_pkg::*;
#(
  parameter int DEPTH  = 1024,
  parameter int DATA_W = 9
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              wrN,
  input  logic              rdN,
  input  logic              rewindN,
  input  logic              oeN,
  input  logic [DATA_W-1:0] wrData,
  output logic [DATA_W-1:0] rdData,
  output logic              rdValid,
  output logic              fullN,
  output logic              emptyN,
  output logic              halfN,
  output logic              edgeN
);
  localparam int AW = $clog2(DEPTH);

  fifoStb_t      stb;
  logic [AW-1:0] wrAddr, rdAddr;

  rewind_fifo_ctl #(.DEPTH(DEPTH)) ctl_i (
    .clk(clk), .rstN(rstN), .wrN(wrN), .rdN(rdN), .rewindN(rewindN), .oeN(oeN),
    .stb(stb), .wrAddr(wrAddr), .rdAddr(rdAddr),
    .fullN(fullN), .emptyN(emptyN), .halfN(halfN), .edgeN(edgeN)
  );

  rewind_fifo_dp #(.DEPTH(DEPTH), .DATA_W(DATA_W)) dp_i (
    .clk(clk), .rstN(rstN), .stb(stb), .wrAddr(wrAddr), .rdAddr(rdAddr),
    .wrData(wrData), .rdData(rdData), .rdValid(rdValid)
  );
endmodule

// File: rtl/rewind_fifo_chk.sv
module rewind_fifo_chk #(
  parameter int DATA_W = 9
) (
  input logic              clk,
  input logic              rstN,
  input logic              wrN,
  input logic              rdN,
  input logic              rewindN,
  input logic              oeN,
  input logic [DATA_W-1:0] rdData,
  input logic              rdValid,
  input logic              fullN,
  input logic              emptyN,
  input logic              halfN,
  input logic              edgeN
);
  a_r1_reset_flags: assert property (@(posedge clk)
    !rstN |-> (fullN && halfN && !emptyN && !edgeN && !rdValid && rdData == '0));

  a_r2_full_holds: assert property (@(posedge clk) disable iff (!rstN)
    (!fullN && rdN && rewindN) |=> !fullN);

  a_r3_empty_holds: assert property (@(posedge clk) disable iff (!rstN)
    (!emptyN && wrN && rewindN) |=> (!emptyN && !rdValid));

  a_r6_full_implies: assert property (@(posedge clk) disable iff (!rstN)
    !fullN |-> (emptyN && !halfN && !edgeN));

  a_r7_valid_cause: assert property (@(posedge clk) disable iff (!rstN)
    rdValid |-> ($past(!oeN) && $past(!rdN) && $past(rewindN)));

  a_r7_blank_zero: assert property (@(posedge clk) disable iff (!rstN)
    !rdValid |-> (rdData == '0));

  a_r9_steady_occ: assert property (@(posedge clk) disable iff (!rstN)
    (emptyN && fullN && !wrN && !rdN && rewindN) |=> $stable({fullN, emptyN, halfN, edgeN}));
endmodule

bind rewind_fifo rewind_fifo_chk #(.DATA_W(DATA_W)) chk_i (
  .clk(clk), .rstN(rstN), .wrN(wrN), .rdN(rdN), .rewindN(rewindN), .oeN(oeN),
  .rdData(rdData), .rdValid(rdValid), .fullN(fullN), .emptyN(emptyN),
  .halfN(halfN), .edgeN(edgeN)
);

// File: tb/rewind_fifo_tb_top.sv
module rewind_fifo_tb_top;
  localparam int DEPTH = 16;
  localparam int W = 9;

  logic clk = 1'b0;
  always #2 clk = ~clk;

  logic rstN = 1'b0, wrN = 1'b1, rdN = 1'b1, rewindN = 1'b1, oeN = 1'b0;
  logic [W-1:0] wrData = '0;
  logic [W-1:0] rdData;
  logic rdValid, fullN, emptyN, halfN, edgeN;

  rewind_fifo #(.DEPTH(DEPTH), .DATA_W(W)) dut_i (
    .clk(clk), .rstN(rstN), .wrN(wrN), .rdN(rdN), .rewindN(rewindN), .oeN(oeN),
    .wrData(wrData), .rdData(rdData), .rdValid(rdValid),
    .fullN(fullN), .emptyN(emptyN), .halfN(halfN), .edgeN(edgeN)
  );

  int checks = 0, fails = 0;
  logic [W-1:0] model [DEPTH];
  int mwr = 0, mrd = 0;
  bit done = 0;

  task automatic chk(string tag, int act, int exp);
    checks++;
    if (act != exp) begin
      fails++;
      $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
    end
  endtask

  task automatic checkFlags();
    int occ = mwr - mrd;
    chk("R6 fullN", int'(fullN), (occ == DEPTH) ? 0 : 1);
    chk("R6 emptyN", int'(emptyN), (occ == 0) ? 0 : 1);
    chk("R5 halfN", int'(halfN), (occ > DEPTH / 2) ? 0 : 1);
    chk("R4 edgeN", int'(edgeN), (occ < DEPTH / 8 || occ > DEPTH - DEPTH / 8) ? 0 : 1);
  endtask

  task automatic step(string tag, bit wr, bit rd, bit rew, bit oe, logic [W-1:0] d);
    int occ;
    bit rdAcc, wrAcc;
    logic [W-1:0] expD;
    @(negedge clk);
    wrN = !wr; rdN = !rd; rewindN = !rew; oeN = !oe; wrData = d;
    @(posedge clk);
    occ = mwr - mrd;
    rdAcc = !rew && rd && occ > 0;
    wrAcc = !rew && wr && occ < DEPTH;
    expD = model[mrd % DEPTH];
    if (rew) mrd = 0;
    else begin
      if (wrAcc) begin model[mwr % DEPTH] = d; mwr++; end
      if (rdAcc) mrd++;
    end
    #1;
    chk({tag, " rdValid"}, int'(rdValid), int'(rdAcc && oe));
    chk({tag, " rdData"}, int'(rdData), (rdAcc && oe) ? int'(expD) : 0);
    checkFlags();
  endtask

  task automatic doReset();
    @(negedge clk);
    rstN = 1'b0; wrN = 1'b0; rdN = 1'b0; rewindN = 1'b1; wrData = 9'h155;
    @(posedge clk); @(posedge clk); #1;
    mwr = 0; mrd = 0;
    chk("R1 fullN", int'(fullN), 1);
    chk("R1 halfN", int'(halfN), 1);
    chk("R1 emptyN", int'(emptyN), 0);
    chk("R1 edgeN", int'(edgeN), 0);
    chk("R1 rdValid", int'(rdValid), 0);
    @(negedge clk);
    rstN = 1'b1; wrN = 1'b1; rdN = 1'b1;
    @(posedge clk); #1;
    chk("R11 emptyN after reset", int'(emptyN), 0);
    chk("R11 rdValid after reset", int'(rdValid), 0);
  endtask

  initial begin
    #400000;
    if (!done) begin
      fails++; checks++;
      $display("FAIL watchdog expired");
      $display("%0d/%0d checks passed", checks - fails, checks);
      $finish;
    end
  end

  initial begin
    doReset();
    // R4 R5 R6 R12: fill through every occupancy
    for (int i = 0; i < DEPTH; i++) step("R12 fill", 1, 0, 0, 1, W'(i * 7 + 3));
    // R2: write while full ignored
    step("R2 write full", 1, 0, 0, 1, 9'h1AA);
    step("R2 idle", 0, 0, 0, 1, '0);
    // R7 R12: drain in order
    for (int i = 0; i < DEPTH; i++) step("R12 drain", 0, 1, 0, 1, '0);
    // R3: read on empty ignored, pointer unmoved
    step("R3 read empty", 0, 1, 0, 1, '0);
    step("R3 write", 1, 0, 0, 1, 9'h0F1);
    step("R3 read back", 0, 1, 0, 1, '0);
    // R7: oe low with no read keeps bus blank
    step("R7 no read", 0, 0, 0, 1, '0);
    // R8: read with output disabled consumes the word
    step("R8 write a", 1, 0, 0, 1, 9'h011);
    step("R8 write b", 1, 0, 0, 1, 9'h022);
    step("R8 hidden read", 0, 1, 0, 0, '0);
    step("R8 next read", 0, 1, 0, 1, '0);
    // R9: simultaneous on empty, mid, full
    step("R9 both empty", 1, 1, 0, 1, 9'h033);
    step("R9 both mid", 1, 1, 0, 1, 9'h044);
    step("R9 both mid2", 1, 1, 0, 1, 9'h055);
    for (int i = 0; i < DEPTH - 1; i++) step("R9 refill", 1, 0, 0, 1, W'(i + 100));
    step("R9 both full", 1, 1, 0, 1, 9'h1FF);
    for (int i = 0; i < DEPTH; i++) step("R9 drain", 0, 1, 0, 1, '0);
    // R10: rewind after partial reads, strobes held during rewind
    doReset();
    for (int i = 0; i < 10; i++) step("R10 load", 1, 0, 0, 1, W'(200 + i * 3));
    for (int i = 0; i < 6; i++) step("R10 part", 0, 1, 0, 1, '0);
    step("R10 rewind", 1, 1, 1, 1, 9'h0AB);
    for (int i = 0; i < 11; i++) step("R10 replay", 0, 1, 0, 1, '0);
    done = 1;
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end
endmodule